// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a TFT panel: line sync, frame sync, a data-enable strobe and the current raster position in pixels and lines. All of its timing comes from three packed 32-bit timing words and a two-bit control word. Every field is held as an offset code. The horizontal porch and sync widths and the vertical sync width are stored minus one. The vertical porches are stored raw. The active width is stored in units of 16 pixels, minus one. Each line runs active pixels, then front porch, then sync, then back porch. The line counter advances once per completed line, and the frame runs through the same four phases vertically.

The counters advance only on cycles where the pixel clock enable is high. The timing words are copied into a shadow set while the raster is stopped, and again at the last pixel of each frame. A write in the middle of a frame therefore takes effect at the next frame. Per-signal polarity bits invert the sync and data-enable outputs. A separate bit selects which pixel-clock edge launches data.

A power sequencer controls the panel supply. The panel supply is switched on only after the raster has been running for a programmable settling interval. When the panel is shut down, the supply is removed first, and the raster stops only after a second settling interval. The interval is counted in system clock cycles (the default is 20 ms at 25 MHz).

Top module: `lcd_raster_timer`

## Requirements
- R1: Each line is (horiz_reg[7:2]+1)*16 active pixels, then horiz_reg[23:16]+1 front-porch pixels, then horiz_reg[15:8]+1 sync pixels, then horiz_reg[31:24]+1 back-porch pixels. The line sync is active only during the sync pixels.
- R2: Each frame is vert_reg[9:0]+1 active lines, then vert_reg[23:16] front-porch lines, then vert_reg[15:10]+1 sync lines, then vert_reg[31:24] back-porch lines. The line count advances once per completed line, and frame sync is active during the sync lines.
- R3: Data enable is active only when the pixel position and the line position are both inside their active regions.
- R4: pol_reg[0] makes line sync active-low, pol_reg[1] makes frame sync active-low, and pol_reg[2] makes data enable active-low. launch_fall_o follows pol_reg[3].
- R5: Raster counters and outputs advance only on cycles with pix_en high, so a half-rate enable doubles the frame length in clock cycles.
- R6: pix_x_o and pix_y_o report the raster position. Each frame starts at position (0,0).
- R7: Timing words written during a frame do not change the current frame. They take effect from the next frame.
- R8: With ctrl_reg[0] (run) and ctrl_reg[1] (panel supply) set from the stopped state, panel_pwr_o rises between STEP_CYCLES and STEP_CYCLES+2 cycles later. It stays low before that, and also while ctrl_reg[1] is clear.
- R9: Clearing either control bit drops panel_pwr_o on the next cycle. If run is cleared, the raster keeps running for STEP_CYCLES cycles and then stops. When stopped, position is (0,0) and the outputs sit at their inactive levels.
- R10: Synchronous reset drives all outputs low.
- R11: The clocks-per-line field pol_reg[25:16] has no effect on the raster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System/pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel clock enable |
| horiz_reg | input | 32 | Horizontal timing word |
| vert_reg | input | 32 | Vertical timing word |
| pol_reg | input | 32 | Polarity bits [3:0], clocks-per-line [25:16] |
| ctrl_reg | input | 2 | [0] run, [1] panel supply request |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| launch_fall_o | output | 1 | Data launched on falling pixel-clock edge |
| panel_pwr_o | output | 1 | Panel supply enable |
| pix_x_o | output | 12 | Pixel position within line |
| pix_y_o | output | 11 | Line position within frame |

## Verification
The properties assume that the active width multiple-of-16 rule holds by encoding. They also assume that the timing words are decoded into a raster whose total fits in the counter widths. Every field in range satisfies this. The properties further assume that reset is applied from time zero, so that the shadow set and the counters start in step. The stimulus only writes timing words whose fields are in range. It drives pix_en either constantly high or toggling every cycle. It changes the control word only between the power-sequence checks, and it waits for the sequencer to reach its stopped state before starting a new check.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

  localparam int HX_W = 12;
  localparam int VY_W = 11;
  localparam int PIX_PER_UNIT_LOG2 = 4;

  typedef enum logic [1:0] {
    PS_OFF,
    PS_WAIT,
    PS_ON,
    PS_DOWN
  } pwr_state_e;

  typedef struct packed {
    logic [HX_W-1:0] act_w;
    logic [HX_W-1:0] sync_beg_x;
    logic [HX_W-1:0] sync_end_x;
    logic [HX_W-1:0] last_x;
    logic [VY_W-1:0] act_h;
    logic [VY_W-1:0] sync_beg_y;
    logic [VY_W-1:0] sync_end_y;
    logic [VY_W-1:0] last_y;
    logic            inv_hs;
    logic            inv_vs;
    logic            inv_de;
    logic            inv_pc;
  } raster_geom_t;

  function automatic raster_geom_t decode_geom(input logic [31:0] hw,
                                               input logic [31:0] vw,
                                               input logic [31:0] pw);
    raster_geom_t g;
    g.act_w      = HX_W'({hw[7:2], {PIX_PER_UNIT_LOG2{1'b0}}}) + HX_W'(1 << PIX_PER_UNIT_LOG2);
    g.sync_beg_x = g.act_w + HX_W'(hw[23:16]) + HX_W'(1);
    g.sync_end_x = g.sync_beg_x + HX_W'(hw[15:8]) + HX_W'(1);
    g.last_x     = g.sync_end_x + HX_W'(hw[31:24]);
    g.act_h      = VY_W'(vw[9:0]) + VY_W'(1);
    g.sync_beg_y = g.act_h + VY_W'(vw[23:16]);
    g.sync_end_y = g.sync_beg_y + VY_W'(vw[15:10]) + VY_W'(1);
    g.last_y     = g.sync_end_y + VY_W'(vw[31:24]) - VY_W'(1);
    g.inv_hs     = pw[0];
    g.inv_vs     = pw[1];
    g.inv_de     = pw[2];
    g.inv_pc     = pw[3];
    return g;
  endfunction

endpackage

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last_val,
  output logic [W-1:0] cnt,
  output logic         at_last
);

  assign at_last = (cnt == last_val);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      if (at_last) cnt <= '0;
      else         cnt <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/lcd_power_seq.sv
module lcd_power_seq
  import lcd_raster_pkg::*;
#(
  parameter int STEP_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_req,
  input  logic pwr_req,
  output logic run_o,
  output logic pwr_o
);

  localparam int TMR_W = $clog2(STEP_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STEP_CYCLES - 1);

  pwr_state_e        state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              tmr_done;

  assign tmr_done = (tmr_q == TMR_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_OFF;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        PS_OFF: begin
          tmr_q <= '0;
          if (en_req) state_q <= PS_WAIT;
        end
        PS_WAIT: begin
          if (!en_req) begin
            state_q <= PS_OFF;
            tmr_q   <= '0;
          end else if (tmr_done) begin
            if (pwr_req) state_q <= PS_ON;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        PS_ON: begin
          tmr_q <= '0;
          if (!en_req || !pwr_req) state_q <= PS_DOWN;
        end
        PS_DOWN: begin
          if (tmr_done) begin
            tmr_q   <= '0;
            state_q <= en_req ? PS_WAIT : PS_OFF;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        default: begin
          state_q <= PS_OFF;
          tmr_q   <= '0;
        end
      endcase
    end
  end

  assign run_o = (state_q != PS_OFF);
  assign pwr_o = (state_q == PS_ON);

endmodule

// File: rtl/lcd_geom_shadow.sv
module lcd_geom_shadow
  import lcd_raster_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         frame_end,
  input  logic [31:0]  horiz_reg,
  input  logic [31:0]  vert_reg,
  input  logic [31:0]  pol_reg,
  output raster_geom_t geom_q,
  output logic         load
);

  raster_geom_t geom_d;
  logic         unused_bits;

  assign geom_d      = decode_geom(horiz_reg, vert_reg, pol_reg);
  assign load        = !run || frame_end;
  assign unused_bits = ^{horiz_reg[1:0], pol_reg[31:4]};

  always_ff @(posedge clk) begin
    if (rst)       geom_q <= '0;
    else if (load) geom_q <= geom_d;
  end

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_raster_pkg::*;
#(
  parameter int STEP_CYCLES = 500000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pix_en,
  input  logic [31:0]     horiz_reg,
  input  logic [31:0]     vert_reg,
  input  logic [31:0]     pol_reg,
  input  logic [1:0]      ctrl_reg,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic            launch_fall_o,
  output logic            panel_pwr_o,
  output logic [HX_W-1:0] pix_x_o,
  output logic [VY_W-1:0] pix_y_o
);

  logic            run;
  raster_geom_t    geom_q;
  logic            geom_load;
  logic [HX_W-1:0] h_cnt;
  logic [VY_W-1:0] v_cnt;
  logic            h_last, v_last;
  logic            h_wrap, frame_end;
  logic            hs_act, vs_act, de_act;

  lcd_power_seq #(.STEP_CYCLES(STEP_CYCLES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .en_req  (ctrl_reg[0]),
    .pwr_req (ctrl_reg[1]),
    .run_o   (run),
    .pwr_o   (panel_pwr_o)
  );

  lcd_geom_shadow u_shadow (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .frame_end (frame_end),
    .horiz_reg (horiz_reg),
    .vert_reg  (vert_reg),
    .pol_reg   (pol_reg),
    .geom_q    (geom_q),
    .load      (geom_load)
  );

  lcd_axis_ctr #(.W(HX_W)) u_hctr (
    .clk      (clk),
    .rst      (rst),
    .clr      (!run),
    .step     (pix_en),
    .last_val (geom_q.last_x),
    .cnt      (h_cnt),
    .at_last  (h_last)
  );

  assign h_wrap    = pix_en && h_last;
  assign frame_end = h_wrap && v_last;

  lcd_axis_ctr #(.W(VY_W)) u_vctr (
    .clk      (clk),
    .rst      (rst),
    .clr      (!run),
    .step     (h_wrap),
    .last_val (geom_q.last_y),
    .cnt      (v_cnt),
    .at_last  (v_last)
  );

  assign hs_act = (h_cnt >= geom_q.sync_beg_x) && (h_cnt < geom_q.sync_end_x);
  assign vs_act = (v_cnt >= geom_q.sync_beg_y) && (v_cnt < geom_q.sync_end_y);
  assign de_act = (h_cnt < geom_q.act_w) && (v_cnt < geom_q.act_h);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      de_o          <= 1'b0;
      launch_fall_o <= 1'b0;
      pix_x_o       <= '0;
      pix_y_o       <= '0;
    end else if (!run) begin
      hsync_o       <= geom_q.inv_hs;
      vsync_o       <= geom_q.inv_vs;
      de_o          <= geom_q.inv_de;
      launch_fall_o <= geom_q.inv_pc;
      pix_x_o       <= '0;
      pix_y_o       <= '0;
    end else if (pix_en) begin
      hsync_o       <= hs_act ^ geom_q.inv_hs;
      vsync_o       <= vs_act ^ geom_q.inv_vs;
      de_o          <= de_act ^ geom_q.inv_de;
      launch_fall_o <= geom_q.inv_pc;
      pix_x_o       <= h_cnt;
      pix_y_o       <= v_cnt;
    end
  end

endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk
  import lcd_raster_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            pix_en,
  input logic            run,
  input logic            pwr,
  input logic            de,
  input logic [HX_W-1:0] pix_x,
  input logic [VY_W-1:0] pix_y,
  input logic            inv_de,
  input logic [HX_W-1:0] act_w,
  input logic [VY_W-1:0] act_h,
  input logic [HX_W-1:0] last_x,
  input logic [VY_W-1:0] last_y,
  input logic            load
);

  a_r8_pwr_only_running: assert property (@(posedge clk) disable iff (rst)
    pwr |-> run);

  a_r8_pwr_rise_after_run: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr) |-> $past(run));

  a_r3_de_in_active: assert property (@(posedge clk) disable iff (rst)
    (de ^ $past(inv_de)) |-> (pix_x < $past(act_w) && pix_y < $past(act_h)));

  a_r6_pos_in_frame: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (pix_x <= $past(last_x) && pix_y <= $past(last_y)));

  a_r9_idle_origin: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> (pix_x == '0 && pix_y == '0));

  a_r5_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    (run && !pix_en) |=> ($stable(pix_x) && $stable(pix_y) && $stable(de)));

  a_r7_geom_hold_in_frame: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> ($stable(act_w) && $stable(last_x) && $stable(last_y)));

endmodule

bind lcd_raster_timer lcd_raster_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .pix_en (pix_en),
  .run    (run),
  .pwr    (panel_pwr_o),
  .de     (de_o),
  .pix_x  (pix_x_o),
  .pix_y  (pix_y_o),
  .inv_de (geom_q.inv_de),
  .act_w  (geom_q.act_w),
  .act_h  (geom_q.act_h),
  .last_x (geom_q.last_x),
  .last_y (geom_q.last_y),
  .load   (geom_load)
);

// File: tb/sim_lcd_raster_timer.sv
module sim_lcd_raster_timer;

  localparam int STEP = 20;
  localparam int NV = 4;
  // stimulus fields and expected line/frame totals
  localparam int T_PPL [NV] = '{0, 1, 0, 2};
  localparam int T_HSW [NV] = '{0, 3, 1, 0};
  localparam int T_HFP [NV] = '{0, 2, 4, 1};
  localparam int T_HBP [NV] = '{0, 1, 2, 0};
  localparam int T_LPP [NV] = '{1, 3, 2, 0};
  localparam int T_VSW [NV] = '{0, 1, 0, 2};
  localparam int T_VFP [NV] = '{0, 2, 1, 0};
  localparam int T_VBP [NV] = '{0, 1, 3, 2};
  localparam int T_POL [NV] = '{0, 3, 12, 15};
  localparam int T_CPL [NV] = '{1023, 5, 0, 47};
  localparam int T_H   [NV] = '{19, 41, 26, 52};
  localparam int T_V   [NV] = '{3, 9, 8, 6};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        pix_en = 1'b1;
  logic [31:0] horiz_reg = '0, vert_reg = '0, pol_reg = '0;
  logic [1:0]  ctrl_reg = '0;
  logic        hsync_o, vsync_o, de_o, launch_fall_o, panel_pwr_o;
  logic [11:0] pix_x_o;
  logic [10:0] pix_y_o;
  bit          gate_half = 1'b0;
  int          checks = 0, fails = 0;

  lcd_raster_timer #(.STEP_CYCLES(STEP)) u0 (
    .clk(clk), .rst(rst), .pix_en(pix_en), .horiz_reg(horiz_reg),
    .vert_reg(vert_reg), .pol_reg(pol_reg), .ctrl_reg(ctrl_reg),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .launch_fall_o(launch_fall_o), .panel_pwr_o(panel_pwr_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
  );

  initial begin
    forever begin
      @(posedge clk); #1;
      if (gate_half) pix_en = ~pix_en;
      else           pix_en = 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic apply_vec(input int i);
    horiz_reg = {T_HBP[i][7:0], T_HFP[i][7:0], T_HSW[i][7:0], T_PPL[i][5:0], 2'b00};
    vert_reg  = {T_VBP[i][7:0], T_VFP[i][7:0], T_VSW[i][5:0], T_LPP[i][9:0]};
    pol_reg   = {6'd0, T_CPL[i][9:0], 12'd0, T_POL[i][3:0]};
  endtask

  task automatic samples(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // measures one frame from a (0,0) start to the next; chg_at>=0 writes vector chg_vec mid-frame
  task automatic measure(input logic [3:0] pol, input int chg_at, input int chg_vec,
                         output int cyc, output int de_n, output int hs_n,
                         output int vs_n, output int hsx, output int vsy);
    bit prev = 1'b1;
    bit cur;
    cyc = 0; de_n = 0; hs_n = 0; vs_n = 0; hsx = -1; vsy = -1;
    forever begin
      @(negedge clk);
      cur = (pix_x_o == 0) && (pix_y_o == 0);
      if (cur && !prev) break;
      prev = cur;
    end
    prev = 1'b1;
    forever begin
      if (cyc == chg_at) apply_vec(chg_vec);
      cyc++;
      if (de_o ^ pol[2]) de_n++;
      if (hsync_o ^ pol[0]) begin
        hs_n++;
        if (hsx < 0) hsx = int'(pix_x_o);
      end
      if (vsync_o ^ pol[1]) begin
        vs_n++;
        if (vsy < 0) vsy = int'(pix_y_o);
      end
      @(negedge clk);
      cur = (pix_x_o == 0) && (pix_y_o == 0);
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
    $finish;
  end

  initial begin
    int cyc, de_n, hs_n, vs_n, hsx, vsy, cnt, x0;
    samples(3);
    // R10 reset state
    chk("R10 hsync", int'(hsync_o), 0);
    chk("R10 de", int'(de_o), 0);
    chk("R10 pix_x", int'(pix_x_o), 0);
    chk("R10 panel_pwr", int'(panel_pwr_o), 0);
    @(posedge clk); #1 rst = 1'b0;

    apply_vec(0);
    samples(2);
    ctrl_reg = 2'b01;
    samples(STEP + 6);
    chk("R8 no supply without request", int'(panel_pwr_o), 0);

    // table walk: R1 R2 R3 R4 R6 R11
    for (int i = 0; i < NV; i++) begin
      int acth, actv;
      logic [3:0] pol;
      pol = T_POL[i][3:0];
      apply_vec(i);
      measure(pol, -1, 0, cyc, de_n, hs_n, vs_n, hsx, vsy);
      acth = (T_PPL[i] + 1) * 16;
      actv = T_LPP[i] + 1;
      chk("R6 R11 frame cycles", cyc, T_H[i] * T_V[i]);
      chk("R3 de count", de_n, acth * actv);
      chk("R1 hsync width", hs_n, (T_HSW[i] + 1) * T_V[i]);
      chk("R2 vsync width", vs_n, (T_VSW[i] + 1) * T_H[i]);
      chk("R1 hsync start", hsx, acth + T_HFP[i] + 1);
      chk("R2 vsync start", vsy, actv + T_VFP[i]);
      chk("R4 launch edge", int'(launch_fall_o), int'(pol[3]));
    end

    // R7 mid-frame write takes effect next frame
    apply_vec(1);
    measure(4'd3, -1, 0, cyc, de_n, hs_n, vs_n, hsx, vsy);
    measure(4'd3, 5, 2, cyc, de_n, hs_n, vs_n, hsx, vsy);
    chk("R7 old frame kept", cyc, T_H[1] * T_V[1]);
    measure(4'd12, -1, 0, cyc, de_n, hs_n, vs_n, hsx, vsy);
    chk("R7 new frame", cyc, T_H[2] * T_V[2]);

    // R5 half-rate pixel enable
    gate_half = 1'b1;
    measure(4'd12, -1, 0, cyc, de_n, hs_n, vs_n, hsx, vsy);
    chk("R5 half-rate frame", cyc, 2 * T_H[2] * T_V[2]);
    gate_half = 1'b0;

    // R8 power-up sequence from stopped
    ctrl_reg = 2'b00;
    samples(STEP + 8);
    chk("R9 stopped origin", int'(pix_x_o), 0);
    ctrl_reg = 2'b11;
    samples(4);
    x0 = int'(pix_x_o);
    samples(1);
    chk("R8 supply low during wait", int'(panel_pwr_o), 0);
    chk("R8 raster runs during wait", int'(pix_x_o), x0 + 1);
    cnt = 5;
    while (!panel_pwr_o && cnt < 100) begin
      samples(1);
      cnt++;
    end
    chk_range("R8 supply delay", cnt, STEP, STEP + 2);

    // R9 drop supply request only
    ctrl_reg = 2'b01;
    samples(1);
    chk("R9 supply drops", int'(panel_pwr_o), 0);
    samples(2 * STEP);
    x0 = int'(pix_x_o);
    samples(1);
    chk("R9 raster keeps running", int'(pix_x_o), (x0 + 1) % T_H[2]);
    chk("R8 no supply without request", int'(panel_pwr_o), 0);

    // R9 full shutdown
    ctrl_reg = 2'b11;
    cnt = 0;
    while (!panel_pwr_o && cnt < 100) begin
      samples(1);
      cnt++;
    end
    chk("R8 supply back on", int'(panel_pwr_o), 1);
    ctrl_reg = 2'b00;
    samples(1);
    chk("R9 supply first off", int'(panel_pwr_o), 0);
    samples(STEP / 2 - 1);
    x0 = int'(pix_x_o);
    samples(1);
    chk("R9 raster after supply off", int'(pix_x_o), (x0 + 1) % T_H[2]);
    samples(STEP / 2 + 3);
    chk("R9 idle x", int'(pix_x_o), 0);
    chk("R9 idle y", int'(pix_y_o), 0);
    chk("R9 R4 idle de level", int'(de_o), 1);
    chk("R9 idle hsync level", int'(hsync_o), 0);

    report();
    $finish;
  end

endmodule